// File: doc/BRIEF.md
# Serial Link Break Generator

This block drives the reset pattern of a two-wire serial master link, which has one clock line and one data line. A one-cycle start request launches a fixed sequence of clock toggles in three back-to-back phases. The first is a lead-in with data at its idle level. The second is a hold phase with data driven low. The third is a long resynchronisation tail with data back at idle. The wire uses inverted logic, so its idle level is high. The resynchronisation tail already contains the ordinary delay that follows a command, so nothing needs to be added after it.

While the sequence runs, the block owns the data output enable and the line transceiver direction, and it keeps busy asserted. A single-cycle done pulse marks completion and tells the requester that the break is complete. The phase lengths default to 50, 256 and 16000 toggles. Each toggle drives the clock low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. Data only changes in a cycle where the clock is low.

Top module: `brk_seq_gen`

## Requirements
- R1: After reset, brk_clk = 1, brk_dat = 1, dat_oe = 0, xcvr_tx = 0, busy = 0 and done = 0.
- R2: A start sampled high while idle makes busy = 1 and brk_clk = 0 in the next cycle.
- R3: Every toggle holds brk_clk low for HALF_CYC cycles and then high for HALF_CYC cycles, with no gap between toggles or between phases.
- R4: The first PRE_TOGGLES toggles (default 50) carry brk_dat = 1.
- R5: The next BRK_TOGGLES toggles (default 256) carry brk_dat = 0. The first of them behaves as an ordinary zero data bit, and the rest are bare toggles.
- R6: The last POST_TOGGLES toggles (default 16000) carry brk_dat = 1.
- R7: brk_dat only changes in a cycle in which brk_clk is 0.
- R8: done is a one-cycle pulse in the cycle after the high half of the final toggle. busy falls in that same cycle, so busy lasts exactly 2*HALF_CYC*(PRE_TOGGLES+BRK_TOGGLES+POST_TOGGLES) cycles.
- R9: A start that arrives while busy = 1 is ignored. The running sequence continues unchanged, and no extra sequence follows it.
- R10: dat_oe and xcvr_tx are 1 exactly while busy = 1.
- R11: brk_clk is 1 whenever busy = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a break sequence |
| brk_clk | output | 1 | Link clock line |
| brk_dat | output | 1 | Link data line (idle high) |
| dat_oe | output | 1 | Data line output enable |
| xcvr_tx | output | 1 | Transceiver direction, 1 = drive |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the phase boundaries. A counter that is off by one would move the falling or rising edge of brk_dat one toggle early or late, and it would change the per-phase toggle counts. It also issues a start in the exact cycle done is high. A design that stays busy one cycle too long would drop that request, and one that restarts its sequence on start would show a clock pattern that diverges in the middle of a run. A data change scheduled in the high half would show up as a transition while brk_clk = 1.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_HOLD   = 2'd2,
    PH_RESYNC = 2'd3
  } brk_phase_e;
endpackage

// File: rtl/brk_half_timer.sv
// Produces the clock level within a toggle and flags the last cycle of each toggle.
module brk_half_timer #(
  parameter int HALF_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic lvl,
  output logic tog_end
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic half_done;

  generate
    if (HALF_CYC == 1) begin : g_nodiv
      assign half_done = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div;
      always_ff @(posedge clk) begin
        if (rst || load || !run) div <= '0;
        else if (div == DW'(HALF_CYC - 1)) div <= '0;
        else div <= div + 1'b1;
      end
      assign half_done = (div == DW'(HALF_CYC - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            lvl <= 1'b1;
    else if (load)      lvl <= 1'b0;
    else if (!run)      lvl <= 1'b1;
    else if (half_done) lvl <= ~lvl;
  end

  assign tog_end = run && lvl && half_done;
endmodule

// File: rtl/brk_toggle_cnt.sv
// Counts finished toggles in the current phase and flags the last one.
module brk_toggle_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear)       cnt <= '0;
    else if (step && last)  cnt <= '0;
    else if (step)          cnt <= cnt + 1'b1;
  end

  // The toggle count never reaches the length of the phase (R4, R5, R6).
  p_cnt_in_phase_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
endmodule

// File: rtl/brk_seq_gen.sv
module brk_seq_gen #(
  parameter int PRE_TOGGLES  = 50,
  parameter int BRK_TOGGLES  = 256,
  parameter int POST_TOGGLES = 16000,
  parameter int HALF_CYC     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic brk_clk,
  output logic brk_dat,
  output logic dat_oe,
  output logic xcvr_tx,
  output logic busy,
  output logic done
);
  import brk_seq_pkg::*;

  localparam int MAXT = (PRE_TOGGLES > BRK_TOGGLES)
                        ? ((PRE_TOGGLES > POST_TOGGLES) ? PRE_TOGGLES : POST_TOGGLES)
                        : ((BRK_TOGGLES > POST_TOGGLES) ? BRK_TOGGLES : POST_TOGGLES);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LEAD_L   = CW'(PRE_TOGGLES);
  localparam logic [CW-1:0] HOLD_L   = CW'(BRK_TOGGLES);
  localparam logic [CW-1:0] RESYNC_L = CW'(POST_TOGGLES);

  brk_phase_e phase;
  logic       lvl, tog_end, last, accept, run;
  logic       dat_q, oe_q, done_q;
  logic [CW-1:0] limit;

  assign run    = (phase != PH_IDLE);
  assign accept = (phase == PH_IDLE) && start;

  always_comb begin
    case (phase)
      PH_HOLD:   limit = HOLD_L;
      PH_RESYNC: limit = RESYNC_L;
      default:   limit = LEAD_L;
    endcase
  end

  brk_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(accept), .run(run),
    .lvl(lvl), .tog_end(tog_end)
  );

  brk_toggle_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clear(!run), .step(tog_end),
    .limit(limit), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      dat_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LEAD;
          oe_q  <= 1'b1;
        end
        PH_LEAD: if (tog_end && last) begin
          phase <= PH_HOLD;
          dat_q <= 1'b0;
        end
        PH_HOLD: if (tog_end && last) begin
          phase <= PH_RESYNC;
          dat_q <= 1'b1;
        end
        default: if (tog_end && last) begin
          phase  <= PH_IDLE;
          oe_q   <= 1'b0;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  assign brk_clk = run ? lvl : 1'b1;
  assign brk_dat = dat_q;
  assign dat_oe  = oe_q;
  assign xcvr_tx = oe_q;
  assign busy    = run;
  assign done    = done_q;

  p_idle_clk_high_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> brk_clk);
  p_dat_moves_low_r7: assert property (@(posedge clk) disable iff (rst)
    (brk_dat != $past(brk_dat)) |-> !brk_clk);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_ends_run_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_oe_follows_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (dat_oe == busy) && (xcvr_tx == busy));
  p_run_needs_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  p_hold_low_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD) |-> !brk_dat);
endmodule

// File: tb/sim_brk_seq_gen.sv
module sim_brk_seq_gen;
  localparam int PRE = 50, BRK = 256, POST = 16000, H = 1;
  localparam int TOG = 2 * H;
  localparam int RUNLEN = TOG * (PRE + BRK + POST);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic brk_clk, brk_dat, dat_oe, xcvr_tx, busy, done;

  brk_seq_gen #(.PRE_TOGGLES(PRE), .BRK_TOGGLES(BRK), .POST_TOGGLES(POST), .HALF_CYC(H)) u0 (
    .clk(clk), .rst(rst), .start(start), .brk_clk(brk_clk), .brk_dat(brk_dat),
    .dat_oe(dat_oe), .xcvr_tx(xcvr_tx), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: position within the run in cycles.
  bit m_busy = 1'b0, m_done = 1'b0;
  int m_pos = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_pos = 0;
    end else if (!m_busy) begin
      m_done = 1'b0;
      if (start) begin m_busy = 1'b1; m_pos = 0; end
    end else begin
      m_done = 1'b0;
      m_pos++;
      if (m_pos == RUNLEN) begin m_busy = 1'b0; m_done = 1'b1; end
    end
  end

  // Per-run phase tallies from observed falling clock edges.
  bit prev_clk = 1'b1, prev_dat = 1'b1;
  int c_pre = 0, c_brk = 0, c_post = 0;

  always @(negedge clk) begin
    if (cmp_en) begin
      int idx;
      bit e_clk, e_dat;
      string dreq;
      idx   = m_pos / TOG;
      e_clk = m_busy ? ((m_pos % TOG) >= H) : 1'b1;
      e_dat = (m_busy && idx >= PRE && idx < PRE + BRK) ? 1'b0 : 1'b1;
      dreq  = (idx < PRE) ? "R4" : ((idx < PRE + BRK) ? "R5" : "R6");
      if (!m_busy) dreq = "R1";
      check(brk_clk == e_clk, m_busy ? "R3" : "R11", "brk_clk", brk_clk, e_clk);
      check(brk_dat == e_dat, dreq, "brk_dat", brk_dat, e_dat);
      check(dat_oe == m_busy && xcvr_tx == m_busy, "R10", "oe/tx", {dat_oe, xcvr_tx}, {m_busy, m_busy});
      check(busy == m_busy, "R9", "busy", busy, m_busy);
      check(done == m_done, "R8", "done", done, m_done);
      if (brk_dat != prev_dat) check(brk_clk == 1'b0, "R7", "clk at data change", brk_clk, 0);
      if (busy && !brk_clk && prev_clk) begin
        if (!brk_dat) c_brk++;
        else if (c_brk == 0) c_pre++;
        else c_post++;
      end
      if (done) begin
        check(c_pre == PRE, "R4", "lead toggles", c_pre, PRE);
        check(c_brk == BRK, "R5", "hold toggles", c_brk, BRK);
        check(c_post == POST, "R6", "resync toggles", c_post, POST);
        c_pre = 0; c_brk = 0; c_post = 0;
      end
    end
    prev_clk = brk_clk;
    prev_dat = brk_dat;
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(brk_clk && brk_dat && !dat_oe && !xcvr_tx && !busy && !done, "R1", "reset state",
          {brk_clk, brk_dat, dat_oe, xcvr_tx, busy, done}, 6'b110000);
    cmp_en = 1'b1;
    // first run
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy == 1'b1 && brk_clk == 1'b0, "R2", "launch", {busy, brk_clk}, 2'b10);
    repeat (1000) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R9: ignored mid-run
    wait_done();
    // back-to-back start in the done cycle
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2", "restart on done cycle", busy, 1);
    repeat (2 * TOG * PRE + 3) @(negedge clk);
    start = 1'b1; repeat (3) @(negedge clk); start = 1'b0;  // R9: held start in hold phase
    wait_done();
    repeat (20) @(negedge clk);
    check(brk_clk == 1'b1 && busy == 1'b0, "R11", "idle after runs", {brk_clk, busy}, 2'b10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule